// File: doc/BRIEF.md
# Power mode and shipping supervisor

This block is the digital supervisor that decides whether a battery-powered device is running and which source feeds its system rail. It reads comparator flags for the charger input (undervoltage and over-voltage), two battery level flags (above the over-discharge cut-off, above the higher release level), a discharge overcurrent flag and a system-rail short flag. It also reads the shutdown and wake pins and a millisecond tick. From these it drives a registered source select for the system rail, the regulator enable, and the enable for the battery-measure path.

The supervisor has one running state and three off states: shipping (shutdown), over-discharge and fault. It comes out of reset in shipping. An off state is left when the input stays valid long enough, or when a deglitched wake pulse arrives while the battery is above the release level. While the input is valid the shutdown pin, the wake pin and the battery-side protections have no effect. Every duration is a parameter counted in ticks.

Top module: `pm_ship_ctrl`

## Requirements
- R1: During and after reset the block is in shipping: `ldo_en`=0, `meas_en`=0 and `sys_src`=2'b00. Source codes are 2'b00 none, 2'b01 input, 2'b10 battery.
- R2: The input is valid when neither `vin_uvlo` nor `vin_ovp` is high. While running, `sys_src` is 2'b01 when the input is valid and 2'b10 otherwise, one clock after the flags change.
- R3: In any off state, an input that stays valid for `TICKS_VIN_HOLD` ticks starts the rail on the following clock, whatever the battery level.
- R4: After leaving an off state, the battery may feed the rail only once `bat_above_rel` has been seen. If the input is lost before that, the block enters over-discharge on the next clock.
- R5: With the input invalid, `sd` high turns the rail and regulator off on the next clock. While the input is valid, `sd` has no effect.
- R6: In an off state, `wake` held for `TICKS_WAKE` ticks starts the rail from the battery on the following clock. This happens only while `bat_above_rel` is high, the input is invalid and there is no rail short. Otherwise `wake` is ignored.
- R7: If `sd` is high when a wake exit occurs, the rail stays on only while `wake` stays high. It turns off on the clock after `wake` falls.
- R8: Running from the battery, if `bat_above_cut` stays low for `TICKS_ODC` ticks, the block turns off on the following clock.
- R9: Running from the battery, if `dis_oc` stays high for `TICKS_OC` ticks, the block enters fault. `sys_short` causes the same fault on the next clock. Both flags are ignored while the input is valid. A fault is cleared by the input-hold exit or the wake exit.
- R10: `meas_en` is high one clock after `meas_req` is high while running, provided `dis_oc` and `sys_short` are low and `bat_above_cut` is high. Otherwise `meas_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ms_tick | input | 1 | One-cycle timebase pulse for all deglitch windows |
| vin_uvlo | input | 1 | Input below the undervoltage lock-out |
| vin_ovp | input | 1 | Input above the over-voltage limit |
| bat_above_cut | input | 1 | Battery above the over-discharge cut-off |
| bat_above_rel | input | 1 | Battery above the release level |
| dis_oc | input | 1 | Discharge overcurrent detected |
| sys_short | input | 1 | System rail short detected |
| sd | input | 1 | Shutdown request pin |
| wake | input | 1 | Wake pin |
| meas_req | input | 1 | Battery-measure path request pin |
| sys_src | output | 2 | Rail source select: 00 none, 01 input, 10 battery |
| ldo_en | output | 1 | Regulator enable |
| meas_en | output | 1 | Battery-measure switch enable |

## Verification
A flag change that acts directly (input validity, shutdown, rail short, release loss, measure gating) shows at the outputs one clock after it is applied. A condition that must be held for N ticks shows at the outputs on clock N+1, because the counter first has to reach its limit and the state register then updates. The bench drives every input on the falling edge and samples one falling edge later. It sweeps hold lengths through each window, so it checks that the outputs are still off after clock N and on after clock N+1.

// File: rtl/pm_ship_pkg.sv
package pm_ship_pkg;
  typedef enum logic [1:0] {
    PM_SHIP  = 2'd0,
    PM_ODC   = 2'd1,
    PM_FAULT = 2'd2,
    PM_RUN   = 2'd3
  } pm_state_t;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_VIN  = 2'd1,
    SRC_BAT  = 2'd2
  } pm_src_t;
endpackage

// File: rtl/pm_deglitch.sv
module pm_deglitch #(
  parameter int unsigned LIMIT = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic cond,
  output logic done
);
  localparam int unsigned W = $clog2(LIMIT + 1);
  localparam logic [W-1:0] LIM_W = W'(LIMIT);

  logic [W-1:0] cnt_q;

  // counts ticks while cond holds, saturates at LIMIT, clears when cond drops
  always_ff @(posedge clk) begin
    if (rst || !cond) begin
      cnt_q <= '0;
    end else if (tick && (cnt_q != LIM_W)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign done = (cnt_q == LIM_W);
endmodule

// File: rtl/pm_mode_fsm.sv
module pm_mode_fsm
  import pm_ship_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      vin_ok,
  input  logic      bat_rel,
  input  logic      sd_i,
  input  logic      wake_i,
  input  logic      short_i,
  input  logic      in_done,
  input  logic      wake_done,
  input  logic      odc_done,
  input  logic      oc_done,
  output pm_state_t st_q,
  output pm_state_t st_d
);
  logic need_rel_q, need_rel_d;
  logic hold_q, hold_d;

  always_comb begin
    st_d       = st_q;
    need_rel_d = need_rel_q;
    hold_d     = hold_q & wake_i;
    if (st_q != PM_RUN) begin
      need_rel_d = 1'b1;
      hold_d     = 1'b0;
      if (in_done && vin_ok) begin
        st_d       = PM_RUN;
        need_rel_d = ~bat_rel;
      end else if (wake_done && wake_i && !vin_ok && bat_rel && !short_i) begin
        st_d       = PM_RUN;
        need_rel_d = 1'b0;
        hold_d     = 1'b1;
      end
    end else begin
      need_rel_d = need_rel_q & ~bat_rel;
      if (!vin_ok) begin
        if (short_i || oc_done) begin
          st_d = PM_FAULT;
        end else if (sd_i && !(hold_q && wake_i)) begin
          st_d = PM_SHIP;
        end else if (odc_done || (need_rel_q && !bat_rel)) begin
          st_d = PM_ODC;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= PM_SHIP;
      need_rel_q <= 1'b1;
      hold_q     <= 1'b0;
    end else begin
      st_q       <= st_d;
      need_rel_q <= need_rel_d;
      hold_q     <= hold_d;
    end
  end
endmodule

// File: rtl/pm_out_reg.sv
module pm_out_reg
  import pm_ship_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  pm_state_t st_d,
  input  logic      vin_ok,
  input  logic      meas_req,
  input  logic      dis_oc,
  input  logic      sys_short,
  input  logic      bat_cut,
  output logic [1:0] sys_src,
  output logic      ldo_en,
  output logic      meas_en
);
  logic run_next;
  assign run_next = (st_d == PM_RUN);

  always_ff @(posedge clk) begin
    if (rst) begin
      sys_src <= SRC_NONE;
      ldo_en  <= 1'b0;
      meas_en <= 1'b0;
    end else begin
      ldo_en  <= run_next;
      sys_src <= !run_next ? SRC_NONE : (vin_ok ? SRC_VIN : SRC_BAT);
      meas_en <= run_next && meas_req && !dis_oc && !sys_short && bat_cut;
    end
  end
endmodule

// File: rtl/pm_ship_ctrl.sv
module pm_ship_ctrl
  import pm_ship_pkg::*;
#(
  parameter int unsigned TICKS_VIN_HOLD = 250,
  parameter int unsigned TICKS_WAKE     = 1200,
  parameter int unsigned TICKS_ODC      = 20,
  parameter int unsigned TICKS_OC       = 10
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ms_tick,
  input  logic       vin_uvlo,
  input  logic       vin_ovp,
  input  logic       bat_above_cut,
  input  logic       bat_above_rel,
  input  logic       dis_oc,
  input  logic       sys_short,
  input  logic       sd,
  input  logic       wake,
  input  logic       meas_req,
  output logic [1:0] sys_src,
  output logic       ldo_en,
  output logic       meas_en
);
  pm_state_t st_q, st_d;
  logic vin_ok, off;
  logic in_done, wake_done, odc_done, oc_done;

  assign vin_ok = !vin_uvlo && !vin_ovp;
  assign off    = (st_q != PM_RUN);

  pm_deglitch #(.LIMIT(TICKS_VIN_HOLD)) u_dg_vin (
    .clk(clk), .rst(rst), .tick(ms_tick),
    .cond(off && vin_ok), .done(in_done));

  pm_deglitch #(.LIMIT(TICKS_WAKE)) u_dg_wake (
    .clk(clk), .rst(rst), .tick(ms_tick),
    .cond(off && wake && !vin_ok), .done(wake_done));

  pm_deglitch #(.LIMIT(TICKS_ODC)) u_dg_odc (
    .clk(clk), .rst(rst), .tick(ms_tick),
    .cond(!off && !vin_ok && !bat_above_cut), .done(odc_done));

  pm_deglitch #(.LIMIT(TICKS_OC)) u_dg_oc (
    .clk(clk), .rst(rst), .tick(ms_tick),
    .cond(!off && !vin_ok && dis_oc), .done(oc_done));

  pm_mode_fsm u_fsm (
    .clk(clk), .rst(rst), .vin_ok(vin_ok), .bat_rel(bat_above_rel),
    .sd_i(sd), .wake_i(wake), .short_i(sys_short),
    .in_done(in_done), .wake_done(wake_done),
    .odc_done(odc_done), .oc_done(oc_done),
    .st_q(st_q), .st_d(st_d));

  pm_out_reg u_out (
    .clk(clk), .rst(rst), .st_d(st_d), .vin_ok(vin_ok),
    .meas_req(meas_req), .dis_oc(dis_oc), .sys_short(sys_short),
    .bat_cut(bat_above_cut),
    .sys_src(sys_src), .ldo_en(ldo_en), .meas_en(meas_en));
endmodule

// File: rtl/pm_ship_ctrl_chk.sv
module pm_ship_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       vin_uvlo,
  input logic       vin_ovp,
  input logic       sd,
  input logic       wake,
  input logic       sys_short,
  input logic       meas_req,
  input logic [1:0] sys_src,
  input logic       ldo_en,
  input logic       meas_en
);
  // R1
  rail_off_chk: assert property (@(posedge clk) disable iff (rst)
    !ldo_en |-> sys_src == 2'b00);

  // R2
  vin_src_chk: assert property (@(posedge clk) disable iff (rst)
    sys_src == 2'b01 |-> $past(!vin_uvlo && !vin_ovp));

  // R5
  vin_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (ldo_en && !vin_uvlo && !vin_ovp) |=> (ldo_en && sys_src == 2'b01));

  // R5
  sd_off_chk: assert property (@(posedge clk) disable iff (rst)
    (sd && (vin_uvlo || vin_ovp) && !wake) |=> !ldo_en);

  // R9
  short_off_chk: assert property (@(posedge clk) disable iff (rst)
    (sys_short && (vin_uvlo || vin_ovp)) |=> !ldo_en);

  // R10
  meas_gate_chk: assert property (@(posedge clk) disable iff (rst)
    meas_en |-> (ldo_en && $past(meas_req && !sys_short)));
endmodule

bind pm_ship_ctrl pm_ship_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .vin_uvlo(vin_uvlo), .vin_ovp(vin_ovp),
  .sd(sd), .wake(wake), .sys_short(sys_short), .meas_req(meas_req),
  .sys_src(sys_src), .ldo_en(ldo_en), .meas_en(meas_en));

// File: tb/tb_pm_ship_ctrl.sv
module tb_pm_ship_ctrl;
  localparam int H  = 6;
  localparam int W  = 3;
  localparam int OD = 2;
  localparam int OC = 2;
  localparam int OFF    = 0;
  localparam int ON_IN  = 5;  // {ldo_en, sys_src} = 1,01
  localparam int ON_BAT = 6;  // 1,10

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ms_tick = 1'b1;
  logic vin_uvlo = 1'b1, vin_ovp = 1'b0;
  logic bat_above_cut = 1'b0, bat_above_rel = 1'b0;
  logic dis_oc = 1'b0, sys_short = 1'b0;
  logic sd = 1'b0, wake = 1'b0, meas_req = 1'b0;
  logic [1:0] sys_src;
  logic ldo_en, meas_en;

  int checks = 0;
  int errors = 0;
  bit done_run = 1'b0;

  always #10 clk = ~clk;

  pm_ship_ctrl #(.TICKS_VIN_HOLD(H), .TICKS_WAKE(W),
                 .TICKS_ODC(OD), .TICKS_OC(OC)) dut (
    .clk(clk), .rst(rst), .ms_tick(ms_tick),
    .vin_uvlo(vin_uvlo), .vin_ovp(vin_ovp),
    .bat_above_cut(bat_above_cut), .bat_above_rel(bat_above_rel),
    .dis_oc(dis_oc), .sys_short(sys_short), .sd(sd), .wake(wake),
    .meas_req(meas_req), .sys_src(sys_src), .ldo_en(ldo_en),
    .meas_en(meas_en));

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic chk_rail(input string tag, input int exp);
    chk(tag, int'({ldo_en, sys_src}), exp);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(20 * 20000);
    if (!done_run) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got 0 expected 1");
      finish_run();
    end
  end

  initial begin
    step(3);
    chk_rail("R1 rail in reset", OFF);
    chk("R1 meas in reset", int'(meas_en), 0);
    rst = 1'b0;
    step(1);
    chk_rail("R1 rail after reset", OFF);

    // R3: input hold sweep, depleted battery
    meas_req = 1'b1;
    vin_uvlo = 1'b0;
    for (int k = 1; k <= H + 2; k++) begin
      step(1);
      chk_rail("R3 input hold", (k >= H + 1) ? ON_IN : OFF);
    end
    // R5: sd ignored with valid input
    sd = 1'b1;
    step(2);
    chk_rail("R5 sd ignored on input", ON_IN);
    chk("R10 meas open below cut", int'(meas_en), 0);
    bat_above_cut = 1'b1;
    step(1);
    chk("R10 meas closed", int'(meas_en), 1);
    sd = 1'b0;

    // R4: input lost before release
    vin_uvlo = 1'b1;
    step(1);
    chk_rail("R4 no release", OFF);

    // R2: flag sweep while running with released battery
    bat_above_rel = 1'b1;
    vin_uvlo = 1'b0;
    step(H + 1);
    chk_rail("R3 exit from over-discharge", ON_IN);
    for (int i = 0; i < 4; i++) begin
      {vin_uvlo, vin_ovp} = 2'(i);
      step(1);
      chk_rail("R2 source", (i == 0) ? ON_IN : ON_BAT);
    end
    vin_ovp = 1'b0;

    // R5: sd in battery mode
    sd = 1'b1;
    step(1);
    chk_rail("R5 sd shutdown", OFF);
    sd = 1'b0;

    // R6: wake below release
    bat_above_rel = 1'b0;
    wake = 1'b1;
    for (int k = 1; k <= W + 3; k++) begin
      step(1);
      chk_rail("R6 wake below release", OFF);
    end
    wake = 1'b0;
    step(1);
    bat_above_rel = 1'b1;
    // R6: wake ignored with valid input (input window not yet complete)
    vin_uvlo = 1'b0;
    wake = 1'b1;
    for (int k = 1; k <= H - 1; k++) begin
      step(1);
      chk_rail("R6 wake ignored on input", OFF);
    end
    vin_uvlo = 1'b1;
    wake = 1'b0;
    step(1);
    chk_rail("R6 off after aborted input", OFF);
    // R6: wake sweep
    wake = 1'b1;
    for (int k = 1; k <= W + 2; k++) begin
      step(1);
      chk_rail("R6 wake hold", (k >= W + 1) ? ON_BAT : OFF);
    end
    wake = 1'b0;
    step(2);
    chk_rail("R6 stays on after wake", ON_BAT);

    // R7: wake while sd high
    sd = 1'b1;
    step(1);
    chk_rail("R7 enter shutdown", OFF);
    wake = 1'b1;
    step(W + 1);
    chk_rail("R7 on during wake", ON_BAT);
    step(3);
    chk_rail("R7 held by wake", ON_BAT);
    wake = 1'b0;
    step(1);
    chk_rail("R7 off after wake", OFF);

    // R8: over-discharge window
    sd = 1'b0;
    wake = 1'b1;
    step(W + 1);
    wake = 1'b0;
    step(1);
    chk_rail("R8 running", ON_BAT);
    bat_above_cut = 1'b0;
    bat_above_rel = 1'b0;
    step(1);
    chk_rail("R8 tick 1", ON_BAT);
    chk("R10 meas open below cut", int'(meas_en), 0);
    step(1);
    chk_rail("R8 tick 2", ON_BAT);
    step(1);
    chk_rail("R8 over-discharge off", OFF);

    // R9: discharge overcurrent
    bat_above_cut = 1'b1;
    bat_above_rel = 1'b1;
    wake = 1'b1;
    step(W + 1);
    chk_rail("R6 exit over-discharge", ON_BAT);
    wake = 1'b0;
    step(1);
    chk("R10 meas closed on battery", int'(meas_en), 1);
    dis_oc = 1'b1;
    step(1);
    chk_rail("R9 oc tick 1", ON_BAT);
    chk("R10 meas open on oc", int'(meas_en), 0);
    step(1);
    chk_rail("R9 oc tick 2", ON_BAT);
    step(1);
    chk_rail("R9 oc off", OFF);
    dis_oc = 1'b0;
    wake = 1'b1;
    step(W + 1);
    chk_rail("R9 wake restores", ON_BAT);
    wake = 1'b0;
    step(1);

    // R9: rail short
    sys_short = 1'b1;
    step(1);
    chk_rail("R9 short off", OFF);
    wake = 1'b1;
    step(W + 3);
    chk_rail("R9 wake blocked by short", OFF);
    wake = 1'b0;
    vin_uvlo = 1'b0;
    step(H + 1);
    chk_rail("R9 input restores", ON_IN);
    step(2);
    chk_rail("R9 short ignored on input", ON_IN);
    chk("R10 meas open on short", int'(meas_en), 0);
    dis_oc = 1'b1;
    step(OC + 2);
    chk_rail("R9 oc ignored on input", ON_IN);

    done_run = 1'b1;
    finish_run();
  end
endmodule